// File: doc/BRIEF.md
# Power-fail protected byte memory

A cycle-based, synthesizable model of a 2048 x 8 static memory with active-low select, read-drive and write strobes. The three-state data bus is modelled as a separate input byte, an output byte and an output-drive qualifier. Every control pin is sampled once on the system clock, so the asynchronous-style protocol becomes a cycle protocol. A write opens when the select and the write strobe are both low. It closes when either one goes back high, and the byte is stored from the last sampled cycle in which both were low.

Three digital supply-status inputs gate access. The first reports that the supply is within tolerance. The second reports that the supply is above the battery switchover level. The third is a sampled battery-low indication. When the supply leaves tolerance, the memory stops driving and ignores its pins. When the supply comes back, the pins stay ignored for a recovery interval given in clock cycles. On each power-up across the switchover level, the battery indication is sampled. If it is low, the next completed write is swallowed and the warning is cleared. Software can detect this by writing a complement and reading it back. The array has no reset and keeps its contents through every supply state and through the system reset.

Top module: `pfsram_top`

## Requirements
- R1: While chip select (`ce_n`) is sampled high, `dout_en` is 0 two cycles later, and a write strobe given during that time does not change any stored byte.
- R2: A write occurs when `ce_n` and `we_n` are both sampled low, at any `oe_n` level. The stored byte is visible to a read started three cycles after the strobes are released.
- R3: A read is `ce_n`=0, `we_n`=1, `oe_n`=0. Two clock edges after these pins are sampled, `dout_en`=1 and `dout` holds the byte at `addr`. With `oe_n`=1, `dout_en` stays 0. `dout` is 0 whenever `dout_en` is 0. Addresses 0 and 2047 are both usable.
- R4: A write ends at the first clock edge where either strobe is sampled high. The address and data sampled at that edge are discarded, and those of the previous edge are stored.
- R5: Pulling `we_n` low during an active read makes `dout_en` 0 within two clock edges.
- R6: When `pwr_ok`=0 is sampled, `dout_en` is 0 two edges later and all pins are ignored. A write that is open when the supply fails is abandoned and leaves the addressed byte unchanged.
- R7: After `pwr_ok` returns to 1, reads and writes are ignored for REC_CYC cycles. Access resumes afterwards without any new pin activity.
- R8: If `bat_low`=1 at the cycle the supply rises above switchover (`pwr_above_sw` 0 to 1), the first completed write afterwards leaves memory unchanged. The second write is stored.
- R9: Stored bytes survive loss of `pwr_ok` and `pwr_above_sw`, and also survive assertion of `rst`.
- R10: With `bat_low`=0 at power-up, the first write is stored normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all pins are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of control state (not of contents) |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read drive enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | AW | Byte address |
| din | input | DW | Write data (input half of the bus) |
| pwr_ok | input | 1 | Supply within tolerance |
| pwr_above_sw | input | 1 | Supply above battery switchover level |
| bat_low | input | 1 | Battery-low sample, read at power-up |
| dout | output | DW | Read data (output half of the bus), 0 when not driven |
| dout_en | output | 1 | Bus drive qualifier, 1 = data driven |

## Verification
Suppose the supply state machine sits in the wrong state or its recovery count is off. Then `dout_en` rises too early or too late after `pwr_ok` returns, which shows within one recovery interval. Suppose the write-open flag or the captured address and data are wrong. Then a later read returns the wrong byte, or a byte that should be intact, three to five cycles after the strobes are released. A warning flag stuck set or stuck clear shows up as a second write that is lost, or as a first write that lands, on the read right after that write.

// File: rtl/pfsram_pkg.sv
package pfsram_pkg;
  typedef enum logic [1:0] {
    PS_OFF,
    PS_DESEL,
    PS_RECOVER,
    PS_ON
  } pwr_state_t;
endpackage

// File: rtl/pfsram_power.sv
module pfsram_power
  import pfsram_pkg::*;
#(
  parameter int REC_CYC = 250000
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic pwr_above_sw,
  input  logic bat_low,
  output logic access_ok,
  output logic bok_set
);
  localparam int CW = $clog2(REC_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(REC_CYC - 1);

  pwr_state_t state;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= PS_OFF;
      cnt     <= '0;
      bok_set <= 1'b0;
    end else begin
      bok_set <= 1'b0;
      case (state)
        PS_OFF: begin
          if (pwr_above_sw) begin
            state   <= PS_DESEL;
            bok_set <= bat_low;
          end
        end
        PS_DESEL: begin
          if (!pwr_above_sw) state <= PS_OFF;
          else if (pwr_ok) begin
            state <= PS_RECOVER;
            cnt   <= '0;
          end
        end
        PS_RECOVER: begin
          if (!pwr_above_sw) state <= PS_OFF;
          else if (!pwr_ok) state <= PS_DESEL;
          else if (cnt == LAST) state <= PS_ON;
          else cnt <= cnt + 1'b1;
        end
        PS_ON: begin
          if (!pwr_above_sw) state <= PS_OFF;
          else if (!pwr_ok) state <= PS_DESEL;
        end
        default: state <= PS_OFF;
      endcase
    end
  end

  assign access_ok = (state == PS_ON);

  AST_ACCESS_NEEDS_SUPPLY: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_ok) |-> !access_ok); // R6

  AST_REC_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LAST); // R7
endmodule

// File: rtl/pfsram_ctrl.sv
module pfsram_ctrl #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          access_ok,
  input  logic          bok_set,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata,
  output logic [AW-1:0] mem_raddr,
  output logic          drive_q
);
  logic          s_ce, s_we, s_oe;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_din;
  logic          wr_act, bok_q;
  logic          wr_on, wr_commit, rd_sel;
  logic [AW-1:0] hold_addr;
  logic [DW-1:0] hold_din;

  assign wr_on     = access_ok & s_ce & s_we;
  assign wr_commit = wr_act & ~wr_on & access_ok;
  assign rd_sel    = access_ok & s_ce & ~s_we & s_oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_ce    <= 1'b0;
      s_we    <= 1'b0;
      s_oe    <= 1'b0;
      wr_act  <= 1'b0;
      bok_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      s_ce    <= ~ce_n;
      s_we    <= ~we_n;
      s_oe    <= ~oe_n;
      wr_act  <= wr_on;
      drive_q <= rd_sel;
      if (bok_set) bok_q <= 1'b1;
      else if (wr_commit) bok_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    s_addr <= addr;
    s_din  <= din;
    if (wr_on) begin
      hold_addr <= s_addr;
      hold_din  <= s_din;
    end
  end

  assign mem_we    = wr_commit & ~bok_q;
  assign mem_waddr = hold_addr;
  assign mem_wdata = hold_din;
  assign mem_raddr = s_addr;

  AST_BOK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (bok_q && wr_commit && !bok_set) |=> !bok_q); // R8

  AST_WR_OPENED_POWERED: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> $past(access_ok)); // R6
endmodule

// File: rtl/pfsram_array.sv
module pfsram_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pfsram_top.sv
module pfsram_top #(
  parameter int AW      = 11,
  parameter int DW      = 8,
  parameter int REC_CYC = 250000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  input  logic          pwr_ok,
  input  logic          pwr_above_sw,
  input  logic          bat_low,
  output logic [DW-1:0] dout,
  output logic          dout_en
);
  logic          access_ok, bok_set, mem_we, drive_q;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic [DW-1:0] mem_wdata, rdata;

  pfsram_power #(.REC_CYC(REC_CYC)) u_power (
    .clk(clk), .rst(rst), .pwr_ok(pwr_ok), .pwr_above_sw(pwr_above_sw),
    .bat_low(bat_low), .access_ok(access_ok), .bok_set(bok_set)
  );

  pfsram_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .access_ok(access_ok), .bok_set(bok_set),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .mem_raddr(mem_raddr), .drive_q(drive_q)
  );

  pfsram_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(mem_raddr), .rdata(rdata)
  );

  assign dout_en = drive_q;
  assign dout    = drive_q ? rdata : '0;

  AST_DESEL_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(ce_n, 2) |-> !dout_en); // R1

  AST_DRIVE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    dout_en |-> ($past(!oe_n, 2) && $past(we_n, 2))); // R3

  AST_SUPPLY_FAIL_QUIET: assert property (@(posedge clk) disable iff (rst)
    !$past(pwr_ok, 2) |-> !dout_en); // R6

  AST_STROBE_KILLS_DRIVE: assert property (@(posedge clk) disable iff (rst)
    $past(!we_n, 2) |-> !dout_en); // R5
endmodule

// File: tb/tb_pfsram_top.sv
module tb_pfsram_top;
  localparam int AW  = 11;
  localparam int DW  = 8;
  localparam int REC = 20;

  logic          clk = 1'b0;
  logic          rst, ce_n, oe_n, we_n, pwr_ok, pwr_above_sw, bat_low;
  logic [AW-1:0] addr;
  logic [DW-1:0] din, dout;
  logic          dout_en;
  int            n_vec = 0;
  int            n_err = 0;

  always #4 clk = ~clk;

  pfsram_top #(.AW(AW), .DW(DW), .REC_CYC(REC)) dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .pwr_ok(pwr_ok), .pwr_above_sw(pwr_above_sw),
    .bat_low(bat_low), .dout(dout), .dout_en(dout_en)
  );

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got en/data %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic oe_low);
    @(negedge clk);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = ~oe_low;
    idle(2);
    we_n = 1'b1; din = ~d;
    idle(1);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(3);
  endtask

  task automatic do_read(input logic [AW-1:0] a, output logic [8:0] got);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    got = {dout_en, dout};
    ce_n = 1'b1; oe_n = 1'b1;
    idle(2);
  endtask

  task automatic power_up_wait();
    idle(REC + 6);
  endtask

  task automatic t_reset();
    logic [8:0] g;
    @(negedge clk);
    chk("R1 reset no drive", {dout_en, dout}, 9'h000);
    do_read(11'd5, g);
    chk("R7 ignored right after reset", g, 9'h000);
    power_up_wait();
  endtask

  task automatic t_basic();
    logic [8:0] g;
    do_write(11'd5, 8'h11, 1'b0);
    do_read(11'd5, g);
    chk("R10 first write stored", g, {1'b1, 8'h11});
    do_write(11'h7FF, 8'h22, 1'b0);
    do_write(11'd0, 8'h33, 1'b1);
    do_read(11'h7FF, g);
    chk("R3 top address", g, {1'b1, 8'h22});
    do_read(11'd0, g);
    chk("R2 write with oe low", g, {1'b1, 8'h33});
    @(negedge clk);
    addr = 11'd5; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    idle(3);
    chk("R3 oe high no drive", {dout_en, dout}, 9'h000);
    ce_n = 1'b1;
    idle(2);
  endtask

  task automatic t_desel();
    logic [8:0] g;
    @(negedge clk);
    addr = 11'd5; din = 8'hEE; ce_n = 1'b1; we_n = 1'b0; oe_n = 1'b0;
    idle(4);
    chk("R1 deselected no drive", {dout_en, dout}, 9'h000);
    we_n = 1'b1; oe_n = 1'b1;
    idle(3);
    do_read(11'd5, g);
    chk("R1 deselected write ignored", g, {1'b1, 8'h11});
  endtask

  task automatic t_ce_end();
    logic [8:0] g;
    @(negedge clk);
    addr = 11'h40; din = 8'hC3; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(2);
    ce_n = 1'b1; din = 8'h3C; addr = 11'h41;
    idle(1);
    we_n = 1'b1;
    idle(3);
    do_read(11'h40, g);
    chk("R4 select-ended write keeps last data", g, {1'b1, 8'hC3});
  endtask

  task automatic t_we_kill();
    logic [8:0] g;
    do_write(11'h20, 8'h40, 1'b0);
    @(negedge clk);
    addr = 11'h20; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(3);
    chk("R3 read drives", {dout_en, dout}, {1'b1, 8'h40});
    din = 8'h5A; we_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R5 strobe disables drive", {dout_en, dout}, 9'h000);
    we_n = 1'b1;
    idle(1);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(3);
    do_read(11'h20, g);
    chk("R2 write during read stored", g, {1'b1, 8'h5A});
  endtask

  task automatic t_power_fail();
    logic [8:0] g;
    do_write(11'd9, 8'h90, 1'b0);
    @(negedge clk);
    addr = 11'd9; din = 8'h99; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
    idle(2);
    pwr_ok = 1'b0;
    idle(3);
    we_n = 1'b1; ce_n = 1'b1;
    idle(2);
    do_read(11'd9, g);
    chk("R6 no drive when out of tolerance", g, 9'h000);
    pwr_above_sw = 1'b0;
    idle(3);
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    pwr_above_sw = 1'b1;
    idle(2);
    pwr_ok = 1'b1;
    power_up_wait();
    do_read(11'd9, g);
    chk("R6 interrupted write abandoned", g, {1'b1, 8'h90});
    do_read(11'd5, g);
    chk("R9 content kept over loss and reset", g, {1'b1, 8'h11});
  endtask

  task automatic t_recovery();
    @(negedge clk);
    pwr_ok = 1'b0;
    idle(3);
    pwr_ok = 1'b1;
    addr = 11'd5; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    idle(REC / 2);
    chk("R7 ignored during recovery", {dout_en, dout}, 9'h000);
    idle(REC);
    chk("R7 access after recovery", {dout_en, dout}, {1'b1, 8'h11});
    ce_n = 1'b1; oe_n = 1'b1;
    idle(2);
  endtask

  task automatic t_battery();
    logic [8:0] g;
    @(negedge clk);
    pwr_ok = 1'b0; pwr_above_sw = 1'b0;
    idle(3);
    bat_low = 1'b1; pwr_above_sw = 1'b1;
    idle(2);
    bat_low = 1'b0; pwr_ok = 1'b1;
    power_up_wait();
    do_write(11'h100, 8'hA5, 1'b0);
    do_read(11'h100, g);
    chk("R8 first write after low battery blocked", {1'b0, g[8] ? 8'h00 : 8'hFF}, 9'h000);
    do_read(11'd5, g);
    chk("R8 other content intact", g, {1'b1, 8'h11});
    do_write(11'd5, 8'h6B, 1'b0);
    do_read(11'd5, g);
    chk("R8 second write stored", g, {1'b1, 8'h6B});
  endtask

  task automatic t_battery_block_value();
    logic [8:0] g;
    do_write(11'h120, 8'h0F, 1'b0);
    @(negedge clk);
    pwr_ok = 1'b0; pwr_above_sw = 1'b0;
    idle(3);
    bat_low = 1'b1; pwr_above_sw = 1'b1;
    idle(2);
    bat_low = 1'b0; pwr_ok = 1'b1;
    power_up_wait();
    do_write(11'h120, 8'hF0, 1'b0);
    do_read(11'h120, g);
    chk("R8 blocked write keeps old byte", g, {1'b1, 8'h0F});
    do_write(11'h120, 8'hF0, 1'b0);
    do_read(11'h120, g);
    chk("R8 flag cleared after one write", g, {1'b1, 8'hF0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run hung, all requirements unverified");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    addr = '0; din = '0;
    pwr_ok = 1'b1; pwr_above_sw = 1'b1; bat_low = 1'b0;
    idle(4);
    rst = 1'b0;
    t_reset();
    t_basic();
    t_desel();
    t_ce_end();
    t_we_kill();
    t_power_fail();
    t_recovery();
    t_battery();
    t_battery_block_value();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  end
endmodule